// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block decides which of eight pending interrupt lines should be raised to the processor. The search for a winner starts at a programmable rotation base and moves upward through the line numbers, wrapping from 7 back to 0. The first pending line found wins. The winner is then checked against the most urgent line that is already being serviced, so that a new request interrupts the current handler only if it outranks it. When nested-cascade mode is on and the instance is the primary controller, the cascade line is left out of that check. This lets a second request from the secondary controller pass through while an earlier one is still in service.

The same search is applied to the in-service vector to report the most urgent line in service, which is the line a non-specific end-of-interrupt would clear. Two helper results give the in-service vector and rotation base that an acknowledge of the current winner would produce. They cover the normal, auto-EOI and rotate-on-auto-EOI cases. The surrounding controller keeps all of this state in its own registers and applies the helpers when an acknowledge happens. The logic is purely combinational. A parameter chooses whether every result goes through one output register stage.

Top module: `rotating_prio_resolver`

## Requirements
- R1: The relative priority of line L is (L - base_i) mod 8, and rank 0 is the most urgent. Among the set bits of pend_i, the line with the smallest rank wins, and grant_line_o reports that line's number (rank + base_i) mod 8.
- R2: When pend_i is all zeros, grant_o is 0 and grant_line_o is 0.
- R3: grant_o is 1 only when the winner's rank is strictly smaller than the rank of the most urgent set bit of the in-service vector used for the comparison. An empty comparison vector counts as rank 8. An equal rank or a lower priority gives grant_o = 0 and grant_line_o = 0.
- R4: When nest_i and primary_i are both 1, bit 2 (the cascade line) of insvc_i is cleared before the comparison of R3. When either input is 0, all bits of insvc_i take part.
- R5: top_svc_o and top_svc_line_o report the most urgent set bit of the raw insvc_i, using the same rotation as R1 and never excluding the cascade line. When insvc_i is zero, both outputs are 0.
- R6: When grant_o is 1 and aeoi_i is 0, insvc_next_o equals insvc_i with bit grant_line_o set, and base_next_o equals base_i.
- R7: When grant_o is 1 and aeoi_i is 1, insvc_next_o equals insvc_i. base_next_o is (grant_line_o + 1) mod 8 if rot_aeoi_i is 1, and base_i otherwise.
- R8: When grant_o is 0, insvc_next_o equals insvc_i and base_next_o equals base_i, whatever aeoi_i and rot_aeoi_i are.
- R9: With the default OUT_REG = 1, every output shows the result for the inputs present at the previous rising clock edge. While rst_n is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Asynchronous active-low reset of the output stage |
| pend_i | input | 8 | Pending requests, already masked |
| insvc_i | input | 8 | In-service vector |
| base_i | input | 3 | Rotation base (line with rank 0) |
| nest_i | input | 1 | Nested-cascade mode enable |
| primary_i | input | 1 | Instance is the primary controller |
| aeoi_i | input | 1 | Auto end-of-interrupt enable |
| rot_aeoi_i | input | 1 | Rotate base on auto end-of-interrupt |
| grant_o | output | 1 | A request beats the in-service level |
| grant_line_o | output | 3 | Winning line number |
| top_svc_o | output | 1 | Some line is in service |
| top_svc_line_o | output | 3 | Most urgent in-service line |
| insvc_next_o | output | 8 | In-service vector after acknowledge |
| base_next_o | output | 3 | Rotation base after acknowledge |

## Verification
Two things happen in one cycle: the request search with its nesting comparison, and the in-service search that reports the line for an end-of-interrupt. They meet on the cascade line. The bench drives line 2 as both pending and in service on a primary with nested-cascade mode on. It expects a grant of line 2 and, in the same cycle, a reported top in-service line of 2. A second vector clears primary_i and expects the grant to disappear while the top in-service line stays the same. For every vector, the expected values come from a separate rank-minimising model and are queued, then compared one clock later against all six outputs at once.

// File: rtl/rpr_pkg.sv
package rpr_pkg;
  localparam int unsigned LINES = 8;
  localparam int unsigned IDW   = $clog2(LINES);
  localparam int unsigned RW    = $clog2(LINES + 1);

  typedef logic [LINES-1:0] vec_t;
  typedef logic [IDW-1:0]   idx_t;
  typedef logic [RW-1:0]    rel_t;

  localparam rel_t REL_NONE = rel_t'(LINES);

  // Smallest p such that bit (p + off) mod LINES is set; REL_NONE if empty.
  function automatic rel_t rel_search(vec_t v, idx_t off);
    rel_t r;
    r = REL_NONE;
    for (int p = LINES - 1; p >= 0; p--) begin
      if (v[idx_t'((p + int'(off)) % LINES)]) r = rel_t'(p);
    end
    return r;
  endfunction

  function automatic idx_t rel_to_line(rel_t r, idx_t off);
    return idx_t'((int'(r) + int'(off)) % LINES);
  endfunction

  function automatic idx_t next_base(idx_t line);
    return idx_t'((int'(line) + 1) % LINES);
  endfunction
endpackage

// File: rtl/rpr_search.sv
module rpr_search
  import rpr_pkg::*;
(
  input  vec_t vec_i,
  input  idx_t off_i,
  output rel_t rel_o,
  output logic hit_o,
  output idx_t line_o
);
  rel_t rel_c;

  always_comb begin
    rel_c  = rel_search(vec_i, off_i);
    hit_o  = (rel_c != REL_NONE);
    line_o = hit_o ? rel_to_line(rel_c, off_i) : '0;
  end

  assign rel_o = rel_c;
endmodule

// File: rtl/rpr_ack_update.sv
module rpr_ack_update
  import rpr_pkg::*;
(
  input  logic grant_i,
  input  idx_t line_i,
  input  vec_t insvc_i,
  input  idx_t base_i,
  input  logic aeoi_i,
  input  logic rot_aeoi_i,
  output vec_t insvc_nx_o,
  output idx_t base_nx_o
);
  always_comb begin
    insvc_nx_o = insvc_i;
    base_nx_o  = base_i;
    if (grant_i) begin
      if (!aeoi_i) insvc_nx_o[line_i] = 1'b1;
      else if (rot_aeoi_i) base_nx_o = next_base(line_i);
    end
  end
endmodule

// File: rtl/rpr_out_stage.sv
module rpr_out_stage #(
  parameter int unsigned WIDTH = 8,
  parameter bit          EN    = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  generate
    if (EN) begin : g_reg
      logic [WIDTH-1:0] q_r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_r <= '0;
        else        q_r <= d_i;
      end
      assign q_o = q_r;
    end else begin : g_pass
      assign q_o = d_i;
    end
  endgenerate
endmodule

// File: rtl/rotating_prio_resolver.sv
module rotating_prio_resolver
  import rpr_pkg::*;
#(
  parameter bit          OUT_REG      = 1'b1,
  parameter int unsigned CASCADE_LINE = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] pend_i,
  input  logic [7:0] insvc_i,
  input  logic [2:0] base_i,
  input  logic       nest_i,
  input  logic       primary_i,
  input  logic       aeoi_i,
  input  logic       rot_aeoi_i,
  output logic       grant_o,
  output logic [2:0] grant_line_o,
  output logic       top_svc_o,
  output logic [2:0] top_svc_line_o,
  output logic [7:0] insvc_next_o,
  output logic [2:0] base_next_o
);
  localparam int unsigned OUTW = 1 + IDW + 1 + IDW + LINES + IDW;

  // Named internal events for the checks below.
  vec_t cmp_vec;
  logic cascade_drop;
  rel_t req_rel, cmp_rel, svc_rel;
  logic req_hit, cmp_hit, svc_hit;
  idx_t req_line, cmp_line, svc_line;
  logic win_valid;
  idx_t win_line;
  vec_t insvc_nx;
  idx_t base_nx;

  assign cascade_drop = nest_i & primary_i;

  always_comb begin
    cmp_vec = insvc_i;
    if (cascade_drop) cmp_vec[CASCADE_LINE] = 1'b0;
  end

  rpr_search u_req (.vec_i(pend_i),  .off_i(base_i), .rel_o(req_rel), .hit_o(req_hit), .line_o(req_line));
  rpr_search u_cmp (.vec_i(cmp_vec), .off_i(base_i), .rel_o(cmp_rel), .hit_o(cmp_hit), .line_o(cmp_line));
  rpr_search u_svc (.vec_i(insvc_i), .off_i(base_i), .rel_o(svc_rel), .hit_o(svc_hit), .line_o(svc_line));

  assign win_valid = req_hit && (req_rel < cmp_rel);
  assign win_line  = win_valid ? req_line : '0;

  rpr_ack_update u_ack (
    .grant_i(win_valid), .line_i(win_line), .insvc_i(insvc_i), .base_i(base_i),
    .aeoi_i(aeoi_i), .rot_aeoi_i(rot_aeoi_i), .insvc_nx_o(insvc_nx), .base_nx_o(base_nx)
  );

  logic [OUTW-1:0] out_d, out_q;
  assign out_d = {win_valid, win_line, svc_hit, svc_line, insvc_nx, base_nx};

  rpr_out_stage #(.WIDTH(OUTW), .EN(OUT_REG)) u_out (
    .clk(clk), .rst_n(rst_n), .d_i(out_d), .q_o(out_q)
  );

  assign {grant_o, grant_line_o, top_svc_o, top_svc_line_o, insvc_next_o, base_next_o} = out_q;

  // R1: a winner is always a pending line
  a_r1_winner_pending: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> pend_i[win_line]);
  // R2: nothing pending, nothing granted
  a_r2_empty_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_i == '0) |-> !win_valid);
  // R3: grant only on strictly higher priority than service level
  a_r3_strict_nesting: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (req_rel < cmp_rel));
  // R4: cascade bit excluded in nested mode on primary
  a_r4_cascade_drop: assert property (@(posedge clk) disable iff (!rst_n)
    cascade_drop |-> !cmp_vec[CASCADE_LINE]);
  // R5: reported top in-service line is set in the raw vector
  a_r5_svc_set: assert property (@(posedge clk) disable iff (!rst_n)
    svc_hit |-> insvc_i[svc_line]);
  // R6: acknowledge without auto-EOI marks the line in service
  a_r6_ack_marks: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && !aeoi_i) |-> (insvc_nx[win_line] && base_nx == base_i));
  // R8: no grant leaves state untouched
  a_r8_no_grant_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !win_valid |-> (insvc_nx == insvc_i && base_nx == base_i));

  generate
    if (OUT_REG) begin : g_chk_reg
      // R9: outputs follow combinational result by one cycle
      a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (grant_o == $past(win_valid) && top_svc_o == $past(svc_hit)));
    end
  endgenerate
endmodule

// File: tb/tb_rotating_prio_resolver.sv
`timescale 1ns/1ps
module tb_rotating_prio_resolver;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] pend_i = '0, insvc_i = '0;
  logic [2:0] base_i = '0;
  logic nest_i = 0, primary_i = 0, aeoi_i = 0, rot_aeoi_i = 0;
  logic grant_o, top_svc_o;
  logic [2:0] grant_line_o, top_svc_line_o, base_next_o;
  logic [7:0] insvc_next_o;

  always #2.5 clk = ~clk;  // 200 MHz

  rotating_prio_resolver dut (
    .clk(clk), .rst_n(rst_n), .pend_i(pend_i), .insvc_i(insvc_i), .base_i(base_i),
    .nest_i(nest_i), .primary_i(primary_i), .aeoi_i(aeoi_i), .rot_aeoi_i(rot_aeoi_i),
    .grant_o(grant_o), .grant_line_o(grant_line_o), .top_svc_o(top_svc_o),
    .top_svc_line_o(top_svc_line_o), .insvc_next_o(insvc_next_o), .base_next_o(base_next_o)
  );

  typedef struct {
    string      tag;
    logic       g;
    logic [2:0] gl;
    logic       s;
    logic [2:0] sl;
    logic [7:0] inx;
    logic [2:0] bnx;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  // Independent model: pick the set bit with the smallest rank (line - base) mod 8.
  function automatic void best(input logic [7:0] v, input logic [2:0] b,
                               output logic found, output logic [2:0] line, output int rank);
    found = 0; line = 0; rank = 8;
    for (int l = 0; l < 8; l++) begin
      int rk;
      rk = (l - int'(b) + 8) % 8;
      if (v[l] && rk < rank) begin rank = rk; line = 3'(l); found = 1; end
    end
  endfunction

  task automatic apply(input string tag, input logic [7:0] p, input logic [7:0] s,
                       input logic [2:0] b, input logic n, input logic pr,
                       input logic ae, input logic ra);
    exp_t e;
    logic fp, fs, fc;
    logic [2:0] lp, ls, lc;
    int rp, rs, rc;
    logic [7:0] cmpv;
    @(negedge clk);
    pend_i = p; insvc_i = s; base_i = b; nest_i = n; primary_i = pr;
    aeoi_i = ae; rot_aeoi_i = ra;
    cmpv = (n && pr) ? (s & 8'hFB) : s;
    best(p, b, fp, lp, rp);
    best(cmpv, b, fc, lc, rc);
    best(s, b, fs, ls, rs);
    e.tag = tag;
    e.g   = fp && (rp < rc);
    e.gl  = e.g ? lp : 3'd0;
    e.s   = fs;
    e.sl  = fs ? ls : 3'd0;
    e.inx = s;
    e.bnx = b;
    if (e.g && !ae) e.inx = s | (8'd1 << lp);
    if (e.g && ae && ra) e.bnx = 3'((int'(lp) + 1) % 8);
    q.push_back(e);
  endtask

  // Monitor: compares one queued item per clock, 1 ns after the edge.
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (grant_o !== e.g || grant_line_o !== e.gl || top_svc_o !== e.s ||
          top_svc_line_o !== e.sl || insvc_next_o !== e.inx || base_next_o !== e.bnx) begin
        fails++;
        $display("FAIL %s (R9 timing): got g=%0b gl=%0d s=%0b sl=%0d inx=%h bnx=%0d exp g=%0b gl=%0d s=%0b sl=%0d inx=%h bnx=%0d",
                 e.tag, grant_o, grant_line_o, top_svc_o, top_svc_line_o, insvc_next_o, base_next_o,
                 e.g, e.gl, e.s, e.sl, e.inx, e.bnx);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] lf;
    pend_i = 8'hFF; insvc_i = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    checks++;  // R9: reset state
    if ({grant_o, grant_line_o, top_svc_o, top_svc_line_o, insvc_next_o, base_next_o} !== '0) begin
      fails++;
      $display("FAIL R9 reset: got %b exp 0",
               {grant_o, grant_line_o, top_svc_o, top_svc_line_o, insvc_next_o, base_next_o});
    end
    @(negedge clk); rst_n = 1'b1;

    apply("R1 base0",          8'h81, 8'h00, 3'd0, 0, 0, 0, 0);
    apply("R1 base1 wraps",    8'h81, 8'h00, 3'd1, 0, 0, 0, 0);
    apply("R1 base5",          8'h30, 8'h00, 3'd5, 0, 0, 0, 0);
    apply("R2 empty",          8'h00, 8'h00, 3'd3, 0, 0, 1, 1);
    apply("R3 equal rank",     8'h08, 8'h08, 3'd0, 0, 0, 0, 0);
    apply("R3 higher wins",    8'h04, 8'h08, 3'd0, 0, 0, 0, 0);
    apply("R3 lower blocked",  8'h10, 8'h08, 3'd0, 0, 0, 0, 0);
    apply("R4 R5 cascade nest", 8'h04, 8'h04, 3'd0, 1, 1, 0, 0);
    apply("R4 not primary",    8'h04, 8'h04, 3'd0, 1, 0, 0, 0);
    apply("R4 nest off",       8'h04, 8'h04, 3'd0, 0, 1, 0, 0);
    apply("R5 rotated svc",    8'h00, 8'h24, 3'd3, 0, 0, 0, 0);
    apply("R6 mark svc",       8'h40, 8'h80, 3'd0, 0, 0, 0, 0);
    apply("R7 rotate wrap",    8'h80, 8'h00, 3'd0, 0, 0, 1, 1);
    apply("R7 aeoi no rot",    8'h20, 8'h00, 3'd2, 0, 0, 1, 0);
    apply("R8 no grant hold",  8'h10, 8'h01, 3'd0, 0, 0, 1, 1);
    lf = 8'hA5;
    for (int i = 0; i < 96; i++) begin
      logic [7:0] sv;
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      sv = {lf[2:0], lf[7:3]} & {lf[0], lf[6], 6'h3F};
      apply("R1 R3 R6 R7 sweep", lf, sv, 3'(i), i[3], i[4], i[5], i[6]);
    end
    @(negedge clk);
    while (q.size() > 0) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule